// File: doc/BRIEF.md
# ASCII Bit-Bang JTAG Command Decoder

This block sits between a byte stream of printable command characters and the pins of a JTAG test access port. Each accepted character is decoded in one cycle. A digit character sets the clock, mode-select and data-in pins together. A reset character drives the test-reset pin and the debug-side reset. A read character returns the sampled test-data-out level as an ASCII digit on a separate response stream. Two further characters switch an indicator output on and off. One character raises a disconnect pulse. Any other character is treated as a protocol violation.

The command stream uses valid/ready. Intake stops while the debug bus reports a transaction in flight, so a host cannot run ahead of pending debug work. Intake also stops while a read-back character waits in the response slot, so no read result is overwritten. Once a violation is seen, the block records it in a flag that stays set until reset. After that it still accepts bytes but acts on none of them.

Top module: `bb_jtag_cmd_decoder`

## Requirements
- R1: Accepting a character 0x30..0x37 sets the pins on the next cycle from (char − 0x30): bit 0 to tdi_o, bit 1 to tms_o, bit 2 to tck_o.
- R2: Accepting a character 0x72..0x75 applies bit 1 of (char − 0x72) on the next cycle. When that bit is 1, trst_o goes high and dbg_rst_n_o goes low. When it is 0, trst_o goes low and dbg_rst_n_o goes high. The pins are left as they were.
- R3: Accepting 0x52 loads the response slot on the next cycle with 0x30 + tdo_i, where tdo_i is sampled in the accept cycle. rsp_valid_o and rsp_data_o then hold steady until rsp_ready_i is seen high.
- R4: 0x42 sets blink_o and 0x62 clears it. Neither one changes the pins, the resets or the response slot.
- R5: Accepting 0x51 raises disconnect_o for exactly the next cycle.
- R6: Any other character sets proto_err_o, which stays set until rst_n. While it is set, accepted characters change no output.
- R7: in_ready_o is low whenever dmi_busy_i is high.
- R8: in_ready_o is low whenever rsp_valid_o is high.
- R9: After reset the outputs are: pins low, trst_o low, dbg_rst_n_o high, blink_o low, proto_err_o low, rsp_valid_o low and disconnect_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Command character valid |
| in_data_i | input | 8 | Command character |
| in_ready_o | output | 1 | Command character accepted when high with valid |
| dmi_busy_i | input | 1 | Debug-bus transaction outstanding |
| tdo_i | input | 1 | Test data out from the TAP |
| tck_o | output | 1 | Test clock pin |
| tms_o | output | 1 | Test mode select pin |
| tdi_o | output | 1 | Test data in pin |
| trst_o | output | 1 | Test reset, active high |
| dbg_rst_n_o | output | 1 | Debug-side reset, active low |
| blink_o | output | 1 | Indicator level |
| disconnect_o | output | 1 | One-cycle disconnect pulse |
| proto_err_o | output | 1 | Sticky protocol-violation flag |
| rsp_valid_o | output | 1 | Read-back character valid |
| rsp_data_o | output | 8 | Read-back character, 0x30 or 0x31 |
| rsp_ready_i | input | 1 | Read-back character consumed |

## Verification
The assertions check the intake rules on every cycle: the stall on a busy debug bus and the stall on a full response slot. They also check that a waiting read-back stays unchanged, that the error flag never clears by itself, that only the two digit codes ever appear in the response, and that each disconnect pulse follows an accepted quit character. Only the bench scenarios can show the mapping from every one of the 256 byte values to its pin, reset, indicator and error effect. The same holds for the tdo value that a read returns and for the silence of the block after a violation.

// File: rtl/bb_cmd_pkg.sv
package bb_cmd_pkg;
  localparam int CHAR_W = 8;
  localparam int PIN_W  = 3;

  localparam logic [CHAR_W-1:0] CH_DIGIT0 = 8'h30;
  localparam logic [CHAR_W-1:0] CH_DIGIT7 = 8'h37;
  localparam logic [CHAR_W-1:0] CH_RST_LO = 8'h72;
  localparam logic [CHAR_W-1:0] CH_RST_HI = 8'h75;
  localparam logic [CHAR_W-1:0] CH_READ   = 8'h52;
  localparam logic [CHAR_W-1:0] CH_BL_ON  = 8'h42;
  localparam logic [CHAR_W-1:0] CH_BL_OFF = 8'h62;
  localparam logic [CHAR_W-1:0] CH_QUIT   = 8'h51;

  typedef enum logic [2:0] {
    K_PIN, K_RST, K_READ, K_BLON, K_BLOFF, K_QUIT, K_BAD
  } cmd_kind_e;

  function automatic cmd_kind_e classify(input logic [CHAR_W-1:0] c);
    if (c >= CH_DIGIT0 && c <= CH_DIGIT7)      return K_PIN;
    else if (c >= CH_RST_LO && c <= CH_RST_HI) return K_RST;
    else if (c == CH_READ)                     return K_READ;
    else if (c == CH_BL_ON)                    return K_BLON;
    else if (c == CH_BL_OFF)                   return K_BLOFF;
    else if (c == CH_QUIT)                     return K_QUIT;
    else                                       return K_BAD;
  endfunction

  // Digit zero has clear low bits, so the offset leaves them unchanged.
  function automatic logic [PIN_W-1:0] pin_bits(input logic [CHAR_W-1:0] c);
    return c[PIN_W-1:0];
  endfunction

  // Offset values 2 and 3 carry the reset bit.
  function automatic logic reset_bit(input logic [CHAR_W-1:0] c);
    return (c - CH_RST_LO) >= 8'd2;
  endfunction

  function automatic logic [CHAR_W-1:0] tdo_char(input logic b);
    return CH_DIGIT0 + {{(CHAR_W-1){1'b0}}, b};
  endfunction
endpackage

// File: rtl/bb_pin_drive.sv
module bb_pin_drive
  import bb_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act,
  input  cmd_kind_e        kind,
  input  logic [PIN_W-1:0] pins_in,
  input  logic             trst_in,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  output logic             trst_o,
  output logic             dbg_rst_n_o,
  output logic             blink_o
);
  logic pin_we, rst_we;
  assign pin_we = act && (kind == K_PIN);
  assign rst_we = act && (kind == K_RST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdi_o <= 1'b0;
      tms_o <= 1'b0;
      tck_o <= 1'b0;
    end else if (pin_we) begin
      tdi_o <= pins_in[0];
      tms_o <= pins_in[1];
      tck_o <= pins_in[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      trst_o <= 1'b0;
    else if (rst_we) trst_o <= trst_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dbg_rst_n_o <= 1'b1;
    else if (rst_we) dbg_rst_n_o <= !trst_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         blink_o <= 1'b0;
    else if (act && kind == K_BLON)     blink_o <= 1'b1;
    else if (act && kind == K_BLOFF)    blink_o <= 1'b0;
  end

  AST_PINS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_we |=> $stable({tck_o, tms_o, tdi_o})) else $error("pins moved"); // R1
endmodule

// File: rtl/bb_readback.sv
module bb_readback
  import bb_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tdo_bit,
  input  logic              rsp_ready_i,
  output logic              rsp_valid_o,
  output logic [CHAR_W-1:0] rsp_data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= CH_DIGIT0;
    end else if (load) begin
      rsp_valid_o <= 1'b1;
      rsp_data_o  <= tdo_char(tdo_bit);
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)))
    else $error("response dropped"); // R3
  AST_RSP_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> (rsp_data_o == 8'h30 || rsp_data_o == 8'h31))
    else $error("bad response char"); // R3
endmodule

// File: rtl/bb_jtag_cmd_decoder.sv
module bb_jtag_cmd_decoder
  import bb_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid_i,
  input  logic [CHAR_W-1:0] in_data_i,
  output logic              in_ready_o,
  input  logic              dmi_busy_i,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              trst_o,
  output logic              dbg_rst_n_o,
  output logic              blink_o,
  output logic              disconnect_o,
  output logic              proto_err_o,
  output logic              rsp_valid_o,
  output logic [CHAR_W-1:0] rsp_data_o,
  input  logic              rsp_ready_i
);
  cmd_kind_e kind;
  logic      accept_w, act_w, quit_w, bad_w;

  assign kind       = classify(in_data_i);
  assign in_ready_o = !dmi_busy_i && !rsp_valid_o;
  assign accept_w   = in_valid_i && in_ready_o;
  assign act_w      = accept_w && !proto_err_o;
  assign quit_w     = act_w && (kind == K_QUIT);
  assign bad_w      = act_w && (kind == K_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     proto_err_o <= 1'b0;
    else if (bad_w) proto_err_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disconnect_o <= 1'b0;
    else        disconnect_o <= quit_w;
  end

  bb_pin_drive u_pins (
    .clk(clk), .rst_n(rst_n), .act(act_w), .kind(kind),
    .pins_in(pin_bits(in_data_i)), .trst_in(reset_bit(in_data_i)),
    .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o), .trst_o(trst_o),
    .dbg_rst_n_o(dbg_rst_n_o), .blink_o(blink_o)
  );

  bb_readback u_rsp (
    .clk(clk), .rst_n(rst_n), .load(act_w && kind == K_READ),
    .tdo_bit(tdo_i), .rsp_ready_i(rsp_ready_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
  );

  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_busy_i |-> !in_ready_o) else $error("intake while busy"); // R7
  AST_STALL_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> !in_ready_o) else $error("intake over full slot"); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err_o |=> proto_err_o) else $error("error flag cleared"); // R6
  AST_DISC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disconnect_o) |-> $past(in_valid_i && in_ready_o && in_data_i == 8'h51))
    else $error("stray disconnect"); // R5
endmodule

// File: tb/bb_jtag_cmd_decoder_tb_top.sv
module bb_jtag_cmd_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, dmi_busy = 1'b0, tdo = 1'b0, rsp_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, tck, tms, tdi, trst, dbg_rst_n, blink, disc, perr, rsp_valid;
  logic [7:0] rsp_data;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  bb_jtag_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .dmi_busy_i(dmi_busy), .tdo_i(tdo),
    .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .trst_o(trst),
    .dbg_rst_n_o(dbg_rst_n), .blink_o(blink), .disconnect_o(disc),
    .proto_err_o(perr), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rsp_ready_i(rsp_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; rsp_ready = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // Present one byte; returns at the negedge after it was accepted.
  task automatic send(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 pins", {tck, tms, tdi}, 3'b000);
    chk("R9 resets", {trst, dbg_rst_n}, 2'b01);
    chk("R9 flags", {blink, perr, rsp_valid, disc}, 4'b0000);
    chk("R9 ready", in_ready, 1'b1);

    // Sweep every byte value, with tdo low then high.
    for (int pass = 0; pass < 2; pass++) begin
      for (int v = 0; v < 256; v++) begin
        logic [7:0] b, d;
        logic is_pin, is_rst, is_bad, exp_trst;
        b = 8'(v);
        do_reset();
        send(8'h35);               // pins = tck1 tms0 tdi1
        tdo = pass[0];
        send(b);
        d = b - 8'h30;
        is_pin = (b >= 8'h30 && b <= 8'h37);
        is_rst = (b >= 8'h72 && b <= 8'h75);
        is_bad = !(is_pin || is_rst || b == 8'h52 || b == 8'h42 ||
                   b == 8'h62 || b == 8'h51);
        exp_trst = is_rst && (((b - 8'h72) & 8'h02) != 0);
        chk("R1 pins", {tck, tms, tdi}, is_pin ? {d[2], d[1], d[0]} : 3'b101);
        chk("R2 trst", {trst, dbg_rst_n}, {exp_trst, !exp_trst});
        chk("R4 blink", blink, b == 8'h42);
        chk("R5 disconnect", disc, b == 8'h51);
        chk("R6 error", perr, is_bad);
        chk("R3 rsp valid", rsp_valid, b == 8'h52);
        if (b == 8'h52) begin
          chk("R3 rsp data", rsp_data, 8'h30 + 8'(pass));
          chk("R8 stall on full", in_ready, 1'b0);
          tdo = !tdo;
          @(negedge clk);
          chk("R3 held", {rsp_valid, rsp_data}, {1'b1, 8'h30 + 8'(pass)});
          rsp_ready = 1'b1;
          @(negedge clk); rsp_ready = 1'b0;
          chk("R3 drained", rsp_valid, 1'b0);
          chk("R8 ready again", in_ready, 1'b1);
        end
        if (b == 8'h51) begin
          @(negedge clk);
          chk("R5 one cycle", disc, 1'b0);
        end
        if (b == 8'h42) begin
          send(8'h62);
          chk("R4 blink off", {blink, tck, tms, tdi}, 4'b0101);
        end
        if (is_bad) begin
          send(8'h32); send(8'h74); send(8'h42);
          chk("R6 ignored", {tck, tms, tdi, trst, blink, perr}, 6'b101001);
        end
      end
    end

    // R7 stall on busy debug bus
    do_reset();
    @(negedge clk); dmi_busy = 1'b1; in_valid = 1'b1; in_data = 8'h37;
    repeat (3) @(negedge clk);
    chk("R7 ready low", in_ready, 1'b0);
    chk("R7 pins unchanged", {tck, tms, tdi}, 3'b000);
    dmi_busy = 1'b0;
    @(negedge clk); in_valid = 1'b0;
    chk("R7 applied after busy", {tck, tms, tdi}, 3'b111);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule